// File: doc/BRIEF.md
# Widening Vector Multiply-Accumulate Unit

This unit executes one family of SIMD integer instructions on a 128-bit vector: a widening multiply whose product is added to, or subtracted from, an accumulator. Each instruction takes two source vectors of narrow elements and one accumulator vector of double-width elements. Each wide lane picks one narrow element from each source, extends both to the wide width as signed or unsigned values, multiplies them, and folds the product into its own accumulator lane.

The issuing logic presents a 32-bit instruction word, the two sources and the accumulator with a valid strobe. One clock later the unit returns the new accumulator vector with an output valid. It also returns two flags. One says the word is not part of this family. The other says the word is in the family but uses the reserved size code. Operand fetch, predication and writeback belong to the surrounding pipeline.

Top module: `wmac_unit`

## Requirements
- R1: A word is in the family only when bits 31:24 equal 8'b01000100, bit 21 is 0 and bits 15:13 equal 3'b010. Any other word sets `no_match`, clears `illegal` and returns an all-zero result.
- R2: A family word with size field bits 23:22 = 2'b00 sets `illegal`, clears `no_match` and returns the accumulator input unchanged.
- R3: Size 2'b01 pairs 8-bit sources with 16-bit lanes, 2'b10 pairs 16-bit sources with 32-bit lanes, and 2'b11 pairs 32-bit sources with 64-bit lanes. Lane i occupies result bits [i*W +: W] for lane width W.
- R4: Bit 10 = 0 feeds wide lane i from narrow element 2i of each source. Bit 10 = 1 feeds it from narrow element 2i+1. Narrow element k occupies bits [k*N +: N].
- R5: Bit 11 = 0 sign-extends both source elements. Bit 11 = 1 zero-extends them.
- R6: Bit 12 = 0 gives accumulator plus product. Bit 12 = 1 gives accumulator minus product.
- R7: All lane arithmetic wraps modulo the lane width, and no lane affects another.
- R8: The register-number fields, bits 20:16, 9:5 and 4:0, have no effect on any output.
- R9: Result and flags appear on the first rising edge after `in_valid` is high. `out_valid` is high in exactly the cycle after an `in_valid` cycle. Reset drives `out_valid` low.
- R10: `illegal` and `no_match` are never both high while `out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| in_valid | input | 1 | Operands and instruction word are present |
| instr | input | 32 | Instruction word |
| src_a | input | 128 | First source vector (narrow elements) |
| src_b | input | 128 | Second source vector (narrow elements) |
| acc_in | input | 128 | Accumulator vector (wide elements) |
| out_valid | output | 1 | Result and flags are valid |
| result | output | 128 | New accumulator vector |
| illegal | output | 1 | Family word with the reserved size code |
| no_match | output | 1 | Word is outside this family |

## Verification
The assertions assume that `rst_n` is already synchronous to `clk`. They also assume that `instr` and `acc_in` are known in every cycle where `in_valid` is high, because the illegal-form check compares the result with the accumulator from the previous cycle. The bench changes inputs only on falling edges and keeps every operand defined. It sweeps all four size codes and all eight combinations of bits 12:10 over fixed corner patterns and pseudo-random vectors. It also fills the register-number fields with random values and sends words that miss each fixed opcode bit group.

// File: rtl/wmac_pkg.sv
package wmac_pkg;
  localparam int unsigned VLEN = 128;
  localparam int unsigned IW   = 32;

  typedef enum logic [1:0] {
    SZ_RSVD = 2'b00,
    SZ_B2H  = 2'b01,
    SZ_H2W  = 2'b10,
    SZ_W2D  = 2'b11
  } wsize_e;

  typedef struct packed {
    logic   member;
    logic   reserved;
    wsize_e size;
    logic   negate;
    logic   zext;
    logic   odd;
  } wmac_op_t;
endpackage

// File: rtl/wmac_decode.sv
module wmac_decode
  import wmac_pkg::*;
#(
  parameter int unsigned IW_P = IW
) (
  input  logic [IW_P-1:0] word,
  output wmac_op_t        op
);
  localparam logic [7:0] MAJOR = 8'b0100_0100;
  localparam logic [2:0] MINOR = 3'b010;

  always_comb begin
    op.member   = (word[31:24] == MAJOR) && !word[21] && (word[15:13] == MINOR);
    op.size     = wsize_e'(word[23:22]);
    op.reserved = op.member && (word[23:22] == 2'b00);
    op.negate   = word[12];
    op.zext     = word[11];
    op.odd      = word[10];
  end
endmodule

// File: rtl/wmac_lane.sv
module wmac_lane #(
  parameter int unsigned NW = 8,
  localparam int unsigned WW = 2 * NW
) (
  input  logic [WW-1:0] a_pair,
  input  logic [WW-1:0] b_pair,
  input  logic [WW-1:0] acc,
  input  logic          odd,
  input  logic          zext,
  input  logic          negate,
  output logic [WW-1:0] sum
);
  logic [NW-1:0] a_n, b_n;
  logic [WW-1:0] a_x, b_x, prod;

  always_comb begin
    a_n  = odd ? a_pair[WW-1:NW] : a_pair[NW-1:0];
    b_n  = odd ? b_pair[WW-1:NW] : b_pair[NW-1:0];
    a_x  = {{NW{~zext & a_n[NW-1]}}, a_n};
    b_x  = {{NW{~zext & b_n[NW-1]}}, b_n};
    prod = a_x * b_x;
    sum  = negate ? (acc - prod) : (acc + prod);
  end
endmodule

// File: rtl/wmac_datapath.sv
module wmac_datapath
  import wmac_pkg::*;
#(
  parameter int unsigned VLEN_P = VLEN,
  localparam int unsigned NSZ   = 3
) (
  input  logic [VLEN_P-1:0] src_a,
  input  logic [VLEN_P-1:0] src_b,
  input  logic [VLEN_P-1:0] acc,
  input  wmac_op_t          op,
  output logic [VLEN_P-1:0] lanes_out
);
  logic [VLEN_P-1:0] per_size [NSZ];

  for (genvar g = 0; g < NSZ; g++) begin : g_size
    localparam int unsigned NW    = 8 << g;
    localparam int unsigned WW    = 2 * NW;
    localparam int unsigned LANES = VLEN_P / WW;
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      wmac_lane #(.NW(NW)) u_lane (
        .a_pair (src_a[l*WW +: WW]),
        .b_pair (src_b[l*WW +: WW]),
        .acc    (acc[l*WW +: WW]),
        .odd    (op.odd),
        .zext   (op.zext),
        .negate (op.negate),
        .sum    (per_size[g][l*WW +: WW])
      );
    end
  end

  always_comb begin
    unique case (op.size)
      SZ_B2H:  lanes_out = per_size[0];
      SZ_H2W:  lanes_out = per_size[1];
      SZ_W2D:  lanes_out = per_size[2];
      default: lanes_out = acc;
    endcase
  end
endmodule

// File: rtl/wmac_unit.sv
module wmac_unit
  import wmac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IW-1:0]    instr,
  input  logic [VLEN-1:0]  src_a,
  input  logic [VLEN-1:0]  src_b,
  input  logic [VLEN-1:0]  acc_in,
  output logic             out_valid,
  output logic [VLEN-1:0]  result,
  output logic             illegal,
  output logic             no_match
);
  wmac_op_t          op;
  logic [VLEN-1:0]   lanes;
  logic [VLEN-1:0]   res_d, res_q;
  logic              ill_d, ill_q, nm_d, nm_q, vld_q;

  wmac_decode #(.IW_P(IW)) u_dec (.word(instr), .op(op));

  wmac_datapath #(.VLEN_P(VLEN)) u_dp (
    .src_a     (src_a),
    .src_b     (src_b),
    .acc       (acc_in),
    .op        (op),
    .lanes_out (lanes)
  );

  // next-state
  always_comb begin
    nm_d  = !op.member;
    ill_d = op.reserved;
    if (!op.member)       res_d = '0;
    else if (op.reserved) res_d = acc_in;
    else                  res_d = lanes;
  end

  // control register with asynchronous reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= in_valid;
  end

  // data registers, enabled by the input strobe
  always_ff @(posedge clk) begin
    if (in_valid) begin
      res_q <= res_d;
      ill_q <= ill_d;
      nm_q  <= nm_d;
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q;
  assign illegal   = ill_q;
  assign no_match  = nm_q;
endmodule

// File: rtl/wmac_unit_chk.sv
module wmac_unit_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [31:0]  instr,
  input logic [127:0] acc_in,
  input logic         out_valid,
  input logic [127:0] result,
  input logic         illegal,
  input logic         no_match
);
  p_valid_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_nomatch_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && no_match) |-> (result == '0));
  p_nomatch_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && instr[31:24] != 8'h44) |=> (no_match && !illegal));
  p_rsvd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && instr[31:21] == 11'b01000100_00_0 && instr[15:13] == 3'b010)
    |=> (illegal && result == $past(acc_in)));
  p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(illegal && no_match));
endmodule

bind wmac_unit wmac_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
  .acc_in(acc_in), .out_valid(out_valid), .result(result),
  .illegal(illegal), .no_match(no_match)
);

// File: tb/test_wmac_unit.sv
`timescale 1ns/1ps
module test_wmac_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [31:0]  instr = '0;
  logic [127:0] src_a = '0, src_b = '0, acc_in = '0;
  logic         out_valid, illegal, no_match;
  logic [127:0] result;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  wmac_unit i_wmac_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .src_a(src_a), .src_b(src_b), .acc_in(acc_in),
    .out_valid(out_valid), .result(result),
    .illegal(illegal), .no_match(no_match)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] model(input logic [31:0] w, input logic [127:0] a,
                                         input logic [127:0] b, input logic [127:0] c);
    logic [127:0] r = '0;
    int nw, lanes, k;
    logic [63:0] m, wm, ea, eb, ca, p, s;
    if (!(w[31:24] == 8'h44 && !w[21] && w[15:13] == 3'b010)) return '0;
    if (w[23:22] == 2'b00) return c;
    nw = 8 << (w[23:22] - 1);
    lanes = 128 / (2 * nw);
    m  = (64'd1 << nw) - 64'd1;
    wm = (nw == 32) ? '1 : ((64'd1 << (2 * nw)) - 64'd1);
    for (int i = 0; i < lanes; i++) begin
      k  = 2 * i + (w[10] ? 1 : 0);
      ea = 64'(a >> (k * nw)) & m;
      eb = 64'(b >> (k * nw)) & m;
      if (!w[11] && ea[nw-1]) ea = ea | ~m;
      if (!w[11] && eb[nw-1]) eb = eb | ~m;
      p  = ea * eb;
      ca = 64'(c >> (i * 2 * nw)) & wm;
      s  = (w[12] ? (ca - p) : (ca + p)) & wm;
      r  = r | (128'(s) << (i * 2 * nw));
    end
    return r;
  endfunction

  task automatic issue(input logic [31:0] w, input logic [127:0] a,
                       input logic [127:0] b, input logic [127:0] c, input string tag);
    logic [127:0] e;
    logic enm, eill;
    @(negedge clk);
    instr = w; src_a = a; src_b = b; acc_in = c; in_valid = 1'b1;
    e    = model(w, a, b, c);
    enm  = !(w[31:24] == 8'h44 && !w[21] && w[15:13] == 3'b010);
    eill = !enm && w[23:22] == 2'b00;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " R9 valid"}, 128'(out_valid), 128'(1));
    chk({tag, " result"}, result, e);
    chk({tag, " R1 no_match"}, 128'(no_match), 128'(enm));
    chk({tag, " R2 illegal"}, 128'(illegal), 128'(eill));
    chk({tag, " R10 excl"}, 128'(illegal & no_match), 128'(0));
  endtask

  function automatic logic [31:0] mkword(input int sz, input int op3);
    logic [31:0] w = $urandom;
    w[31:24] = 8'h44; w[23:22] = sz[1:0]; w[21] = 1'b0;
    w[15:13] = 3'b010; w[12:10] = op3[2:0];
    return w;
  endfunction

  initial begin
    #(200000 * 8);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] pa [7], pb [7], pc [7];
    logic [127:0] r1;
    logic [31:0] w;
    pa[0] = '0;            pb[0] = '1;            pc[0] = '1;
    pa[1] = '1;            pb[1] = '1;            pc[1] = '0;
    pa[2] = {16{8'h80}};   pb[2] = {16{8'h7f}};   pc[2] = {8{16'h8000}};
    pa[3] = {8{16'h7f80}}; pb[3] = {4{32'h8000_0001}}; pc[3] = {2{64'h7fff_ffff_ffff_ffff}};
    for (int v = 4; v < 7; v++) begin
      pa[v] = {$urandom, $urandom, $urandom, $urandom};
      pb[v] = {$urandom, $urandom, $urandom, $urandom};
      pc[v] = {$urandom, $urandom, $urandom, $urandom};
    end
    repeat (3) @(negedge clk);
    chk("R9 reset out_valid", 128'(out_valid), 128'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 idle out_valid", 128'(out_valid), 128'(0));

    // R3 R4 R5 R6 R7 R8 sweep: sizes x op bits x patterns; R2 for size 0
    for (int sz = 0; sz < 4; sz++)
      for (int op3 = 0; op3 < 8; op3++)
        for (int v = 0; v < 7; v++)
          issue(mkword(sz, op3), pa[v], pb[v], pc[v],
                sz == 0 ? "R2 reserved size" : "R3 R4 R5 R6 R7 R8 lanes");

    @(negedge clk);
    chk("R9 valid drops", 128'(out_valid), 128'(0));

    // R8: same operation, different register fields, same result
    w = mkword(2, 5);
    issue(w, pa[5], pb[5], pc[5], "R8 fields a");
    r1 = result;
    w[20:16] = ~w[20:16]; w[9:5] = ~w[9:5]; w[4:0] = ~w[4:0];
    issue(w, pa[5], pb[5], pc[5], "R8 fields b");
    chk("R8 fields equal", result, r1);

    // R1: miss each fixed field
    for (int t = 0; t < 6; t++) begin
      w = mkword(1 + t % 3, t);
      case (t % 3)
        0: w[31:24] = 8'h45;
        1: w[21] = 1'b1;
        default: w[15:13] = 3'b011;
      endcase
      issue(w, pa[t], pb[t], pc[t], "R1 no match");
    end

    // back-to-back issue, R9
    @(negedge clk);
    instr = mkword(3, 3); src_a = pa[4]; src_b = pb[4]; acc_in = pc[4]; in_valid = 1'b1;
    r1 = model(instr, pa[4], pb[4], pc[4]);
    @(negedge clk);
    chk("R9 b2b first", result, r1);
    instr = mkword(1, 6); src_a = pa[6]; src_b = pb[6]; acc_in = pc[6];
    r1 = model(instr, pa[6], pb[6], pc[6]);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 b2b second", result, r1);
    chk("R9 b2b valid", 128'(out_valid), 128'(1));

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule